// File: doc/BRIEF.md
# Clock-Gate and Soft-Reset Controller

This block is one slice of a system controller. It sits on a plain 32-bit register bus (address, write strobe, write data and a read-data return) and produces the enable and select signals that steer the chip's clock tree and its peripheral resets. It does not generate any clock itself. PLLs, dividers and the gating cells are elsewhere in the chip. This block only produces their control levels.

It contains four registers. The first is a read-only status word, loaded from board strap inputs on the first cycle after reset. The second is a clock-control word. It holds thirteen peripheral gate bits, where a set bit stops that clock and a clear bit lets it run. It also holds a PCI clock-run enable, a security-clock ratio select and a 5-bit video half-divider field. The third is a miscellaneous word that holds the PCI 33/66 MHz select. The fourth is a soft-reset word. Writing it launches reset pulses that clear themselves after a fixed number of cycles.

A two-state machine runs the soft-reset pulse. In `SR_IDLE` no reset line is driven. A write to the soft-reset word takes the transition *launch* into `SR_PULSE`. In `SR_PULSE`, a further write takes *extend*: the new bits are ORed into the active set and the cycle counter restarts. When the counter runs out with no write in that cycle, the machine takes *expire* back to `SR_IDLE` and every line drops.

Top module: `sysctl_clkrst`

## Requirements
- R1: After reset every peripheral clock enable is 1, all soft-reset lines are 0, and the clock-control and miscellaneous words read as zero.
- R2: The status word at offset 0x04 reads the oscillator strap in bit 30, the 3-bit bus-speed strap in bits 17:15 and the 2-bit CPU-ratio strap in bits 19:18. All its other bits read 0, and writes to it have no effect.
- R3: Bits 1 to 13 of the clock-control word at offset 0x34 are gate disables. Output `clk_run_en[i]` follows the inverse of bit i+1, with one cycle of delay after the register updates.
- R4: Gate bit 10 (output index 9) can never be set. It reads back 0 and its enable stays 1, even after a write of all ones.
- R5: Clock-control bit 16 drives `pci_clkrun_en`, bit 29 drives `sec_clk_full` (1 = 1:1, 0 = 3/4), and bits 28:24 drive `video_half_div`. All of them read back as written. Bits 0, 14, 15, 17 to 23, 30 and 31 read 0.
- R6: Bit 18 of the miscellaneous word at offset 0x30 drives `pci_66m_sel` (1 = 66 MHz, 0 = 33 MHz). Its other bits read 0.
- R7: A write to the soft-reset word at offset 0x0c drives each written 1-bit on `soft_rst` for exactly PULSE_CYCLES cycles (default 8). The lines then return to 0 with no further write.
- R8: Every soft-reset write also drives line 30, even when the written data is zero.
- R9: A soft-reset write while a pulse is active ORs its bits into the active lines and restarts the full PULSE_CYCLES count.
- R10: A read of offset 0x0c returns a 1 in bit n while `soft_rst[n]` is driven.
- R11: Reads of any other offset return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| strap_osc_30m | input | 1 | Oscillator strap, 1 = 30 MHz crystal |
| strap_bus_speed | input | 3 | Bus-speed strap code |
| strap_cpu_ratio | input | 2 | CPU-to-bus ratio strap code |
| clk_run_en | output | NUM_GATES | Registered per-peripheral clock enables, 1 = run |
| pci_clkrun_en | output | 1 | PCI clock-run enable |
| pci_66m_sel | output | 1 | PCI clock select, 1 = 66 MHz |
| sec_clk_full | output | 1 | Security clock ratio, 1 = 1:1, 0 = 3/4 |
| video_half_div | output | 5 | Video clock half-divider field |
| soft_rst | output | 32 | Self-clearing soft-reset lines |

## Verification
The assertions take three things as given. The strap inputs hold steady from reset onward. A write strobe lasts a single cycle with the address and data stable for that cycle. PULSE_CYCLES is at least 1. The stimulus holds the straps at one fixed code for the whole run. It raises `bus_we` on a falling edge and drops it on the next falling edge, so every write covers exactly one rising edge. It samples outputs only on falling edges, counted from the edge at which the write lands.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    // Register offsets (byte addresses on the bus)
    localparam int OFS_STATUS = 'h04;
    localparam int OFS_SRST   = 'h0c;
    localparam int OFS_MISC   = 'h30;
    localparam int OFS_CLKCTL = 'h34;

    // Status word fields
    localparam int ST_OSC_BIT   = 30;
    localparam int ST_SPEED_LSB = 15;
    localparam int ST_SPEED_W   = 3;
    localparam int ST_RATIO_LSB = 18;
    localparam int ST_RATIO_W   = 2;

    // Clock-control word fields
    localparam int CC_GATE_LSB   = 1;
    localparam int CC_NUM_GATES  = 13;
    localparam int CC_KEEP_BIT   = 10;
    localparam int CC_CLKRUN_BIT = 16;
    localparam int CC_VDIV_LSB   = 24;
    localparam int CC_VDIV_W     = 5;
    localparam int CC_SEC_BIT    = 29;

    // Miscellaneous word fields
    localparam int MC_PCI66_BIT = 18;

    // Soft-reset word
    localparam int SR_CPU1_BIT = 30;

    typedef enum logic [0:0] {
        SR_IDLE  = 1'b0,
        SR_PULSE = 1'b1
    } srst_state_e;

    // Bits of the clock-control word that hold storage
    function automatic logic [31:0] clkctl_mask();
        logic [31:0] m;
        m = '0;
        for (int b = CC_GATE_LSB; b < CC_GATE_LSB + CC_NUM_GATES; b++) begin
            if (b != CC_KEEP_BIT) m[b] = 1'b1;
        end
        m[CC_CLKRUN_BIT] = 1'b1;
        for (int b = CC_VDIV_LSB; b < CC_VDIV_LSB + CC_VDIV_W; b++) m[b] = 1'b1;
        m[CC_SEC_BIT] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/sysctl_regs.sv
module sysctl_regs
    import sysctl_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [31:0]       wdata,
    input  logic              strap_osc,
    input  logic [ST_SPEED_W-1:0] strap_speed,
    input  logic [ST_RATIO_W-1:0] strap_ratio,
    input  logic [31:0]       srst_view,
    output logic [31:0]       rdata,
    output logic [31:0]       clkctl_q,
    output logic [31:0]       misc_q,
    output logic              srst_wr
);

    localparam logic [31:0] CC_MASK = clkctl_mask();
    localparam logic [31:0] MC_MASK = 32'(1) << MC_PCI66_BIT;

    logic        hit_status, hit_srst, hit_misc, hit_clkctl, hit_none;
    logic        loaded_q;
    logic [31:0] status_q;

    always_comb begin
        hit_status = (addr == ADDR_W'(OFS_STATUS));
        hit_srst   = (addr == ADDR_W'(OFS_SRST));
        hit_misc   = (addr == ADDR_W'(OFS_MISC));
        hit_clkctl = (addr == ADDR_W'(OFS_CLKCTL));
        hit_none   = !(hit_status || hit_srst || hit_misc || hit_clkctl);
    end

    assign srst_wr = we && hit_srst;

    // Strap capture on the first cycle out of reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            loaded_q <= 1'b0;
            status_q <= '0;
        end else if (!loaded_q) begin
            loaded_q <= 1'b1;
            status_q <= '0;
            status_q[ST_OSC_BIT] <= strap_osc;
            status_q[ST_SPEED_LSB +: ST_SPEED_W] <= strap_speed;
            status_q[ST_RATIO_LSB +: ST_RATIO_W] <= strap_ratio;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clkctl_q <= '0;
            misc_q   <= '0;
        end else if (we) begin
            if (hit_clkctl) clkctl_q <= wdata & CC_MASK;
            if (hit_misc)   misc_q   <= wdata & MC_MASK;
        end
    end

    always_comb begin
        rdata = '0;
        if (hit_status) rdata = status_q;
        if (hit_srst)   rdata = srst_view;
        if (hit_misc)   rdata = misc_q;
        if (hit_clkctl) rdata = clkctl_q;
    end

    assert_status_ro_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (loaded_q && $past(loaded_q)) |-> $stable(status_q));

    assert_keep_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (we && hit_clkctl) |=> !clkctl_q[CC_KEEP_BIT]);

    assert_unmapped_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (we && hit_none) |=> ($stable(clkctl_q) && $stable(misc_q)));

endmodule

// File: rtl/sysctl_srst.sv
module sysctl_srst
    import sysctl_pkg::*;
#(
    parameter int PULSE_CYCLES = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  logic [31:0] wdata,
    output logic [31:0] lines_q
);

    localparam int CW = $clog2(PULSE_CYCLES + 1);
    localparam logic [31:0] FORCE_MASK = 32'(1) << SR_CPU1_BIT;

    srst_state_e   state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          last_cycle;

    assign last_cycle = (cnt_q == CW'(1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SR_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: launch, extend, expire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SR_IDLE:  if (wr) state_d = SR_PULSE;
            SR_PULSE: if (!wr && last_cycle) state_d = SR_IDLE;
            default:  state_d = SR_IDLE;
        endcase
    end

    // Outputs: active lines and cycle counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lines_q <= '0;
            cnt_q   <= '0;
        end else if (wr) begin
            lines_q <= lines_q | wdata | FORCE_MASK;
            cnt_q   <= CW'(PULSE_CYCLES);
        end else if (state_q == SR_PULSE) begin
            if (last_cycle) begin
                lines_q <= '0;
                cnt_q   <= '0;
            end else begin
                cnt_q <= cnt_q - CW'(1);
            end
        end
    end

    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SR_IDLE) |-> (lines_q == '0));

    assert_expire_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SR_PULSE && last_cycle && !wr) |=> (lines_q == '0));

    assert_cpu1_forced_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> lines_q[SR_CPU1_BIT]);

    assert_extend_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && state_q == SR_PULSE) |=> ((lines_q & $past(lines_q)) == $past(lines_q)));

endmodule

// File: rtl/sysctl_gates.sv
module sysctl_gates
    import sysctl_pkg::*;
#(
    parameter int NUM_GATES = 13,
    parameter int GATE_LSB  = 1,
    parameter int KEEP_BIT  = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [31:0]          ctl,
    output logic [NUM_GATES-1:0] run_en
);

    for (genvar g = 0; g < NUM_GATES; g++) begin : g_gate
        if (GATE_LSB + g == KEEP_BIT) begin : g_keep
            assign run_en[g] = 1'b1;
        end else begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) run_en[g] <= 1'b1;
                else        run_en[g] <= !ctl[GATE_LSB + g];
            end

            assert_gate_lag_R3: assert property (@(posedge clk) disable iff (!rst_n)
                ##1 (run_en[g] == !$past(ctl[GATE_LSB + g])));
        end
    end

endmodule

// File: rtl/sysctl_clkrst.sv
module sysctl_clkrst
    import sysctl_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int NUM_GATES    = CC_NUM_GATES,
    parameter int PULSE_CYCLES = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_we,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    input  logic                  strap_osc_30m,
    input  logic [ST_SPEED_W-1:0] strap_bus_speed,
    input  logic [ST_RATIO_W-1:0] strap_cpu_ratio,
    output logic [NUM_GATES-1:0]  clk_run_en,
    output logic                  pci_clkrun_en,
    output logic                  pci_66m_sel,
    output logic                  sec_clk_full,
    output logic [CC_VDIV_W-1:0]  video_half_div,
    output logic [31:0]           soft_rst
);

    logic [31:0] clkctl_q, misc_q;
    logic        srst_wr;

    sysctl_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr        (bus_addr),
        .we          (bus_we),
        .wdata       (bus_wdata),
        .strap_osc   (strap_osc_30m),
        .strap_speed (strap_bus_speed),
        .strap_ratio (strap_cpu_ratio),
        .srst_view   (soft_rst),
        .rdata       (bus_rdata),
        .clkctl_q    (clkctl_q),
        .misc_q      (misc_q),
        .srst_wr     (srst_wr)
    );

    sysctl_srst #(.PULSE_CYCLES(PULSE_CYCLES)) u_srst (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (srst_wr),
        .wdata   (bus_wdata),
        .lines_q (soft_rst)
    );

    sysctl_gates #(
        .NUM_GATES (NUM_GATES),
        .GATE_LSB  (CC_GATE_LSB),
        .KEEP_BIT  (CC_KEEP_BIT)
    ) u_gates (
        .clk    (clk),
        .rst_n  (rst_n),
        .ctl    (clkctl_q),
        .run_en (clk_run_en)
    );

    assign pci_clkrun_en  = clkctl_q[CC_CLKRUN_BIT];
    assign sec_clk_full   = clkctl_q[CC_SEC_BIT];
    assign video_half_div = clkctl_q[CC_VDIV_LSB +: CC_VDIV_W];
    assign pci_66m_sel    = misc_q[MC_PCI66_BIT];

    assert_misc_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == ADDR_W'(OFS_MISC)) |=> $stable(pci_66m_sel));

endmodule

// File: tb/sysctl_clkrst_test.sv
module sysctl_clkrst_test;

    localparam int PULSE = 8;
    localparam int NG    = 13;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        strap_osc_30m = 1'b1;
    logic [2:0]  strap_bus_speed = 3'b101;
    logic [1:0]  strap_cpu_ratio = 2'b10;
    logic [NG-1:0] clk_run_en;
    logic        pci_clkrun_en, pci_66m_sel, sec_clk_full;
    logic [4:0]  video_half_div;
    logic [31:0] soft_rst;

    int vectors = 0;
    int errors  = 0;

    always #5 clk = ~clk;

    sysctl_clkrst #(.ADDR_W(8), .NUM_GATES(NG), .PULSE_CYCLES(PULSE)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .strap_osc_30m(strap_osc_30m), .strap_bus_speed(strap_bus_speed),
        .strap_cpu_ratio(strap_cpu_ratio), .clk_run_en(clk_run_en),
        .pci_clkrun_en(pci_clkrun_en), .pci_66m_sel(pci_66m_sel),
        .sec_clk_full(sec_clk_full), .video_half_div(video_half_div),
        .soft_rst(soft_rst)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Write lands at the next rising edge; returns on the falling edge after it
    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 enables", 32'(clk_run_en), 32'h1FFF);
        check("R1 soft_rst", soft_rst, 32'h0);
        bus_read(8'h34, d); check("R1 clkctl", d, 32'h0);
        bus_read(8'h30, d); check("R1 misc", d, 32'h0);
    endtask

    task automatic t_status();
        logic [31:0] d;
        logic [31:0] exp = (32'd1 << 30) | (32'd2 << 18) | (32'd5 << 15);
        bus_read(8'h04, d); check("R2 status", d, exp);
        bus_write(8'h04, 32'hFFFF_FFFF);
        bus_read(8'h04, d); check("R2 status read-only", d, exp);
    endtask

    task automatic t_gates();
        logic [12:0] exp = 13'h1FFF & ~((13'd1 << 1) | (13'd1 << 12));
        bus_write(8'h34, (32'd1 << 2) | (32'd1 << 13));
        check("R3 enable lag", 32'(clk_run_en), 32'h1FFF);
        @(negedge clk);
        check("R3 gates off", 32'(clk_run_en), 32'(exp));
        bus_write(8'h34, 32'h0);
        @(negedge clk);
        check("R3 gates on", 32'(clk_run_en), 32'h1FFF);
    endtask

    task automatic t_keep_all_ones();
        logic [31:0] d;
        bus_write(8'h34, 32'hFFFF_FFFF);
        bus_read(8'h34, d); check("R4 R5 readback mask", d, 32'h3F01_3BFE);
        @(negedge clk);
        check("R4 ddr stays on", 32'(clk_run_en), 32'h0200);
        check("R5 clkrun", 32'(pci_clkrun_en), 32'h1);
        check("R5 sec full", 32'(sec_clk_full), 32'h1);
        check("R5 vdiv", 32'(video_half_div), 32'd31);
        bus_write(8'h34, 32'h0);
    endtask

    task automatic t_pci_sec();
        logic [31:0] d;
        bus_write(8'h34, (32'd1 << 16) | (32'd19 << 24));
        check("R5 clkrun on", 32'(pci_clkrun_en), 32'h1);
        check("R5 sec 3/4", 32'(sec_clk_full), 32'h0);
        check("R5 vdiv 19", 32'(video_half_div), 32'd19);
        bus_write(8'h34, 32'd1 << 29);
        check("R5 clkrun off", 32'(pci_clkrun_en), 32'h0);
        check("R5 sec 1:1", 32'(sec_clk_full), 32'h1);
        bus_read(8'h34, d); check("R5 readback", d, 32'h2000_0000);
    endtask

    task automatic t_misc();
        logic [31:0] d;
        bus_write(8'h30, 32'd1 << 18);
        check("R6 66MHz", 32'(pci_66m_sel), 32'h1);
        bus_read(8'h30, d); check("R6 readback", d, 32'h0004_0000);
        bus_write(8'h30, 32'hFFFB_FFFF);
        check("R6 33MHz", 32'(pci_66m_sel), 32'h0);
        bus_read(8'h30, d); check("R6 other bits", d, 32'h0);
    endtask

    task automatic t_srst_basic();
        logic [31:0] d;
        logic [31:0] exp = 32'h0000_0105 | (32'd1 << 30);
        bus_write(8'h0c, 32'h0000_0105);
        check("R7 asserted", soft_rst, exp);
        bus_read(8'h0c, d); check("R10 readback", d, exp);
        repeat (PULSE - 1) @(negedge clk);
        check("R7 last cycle", soft_rst, exp);
        @(negedge clk);
        check("R7 cleared", soft_rst, 32'h0);
        bus_read(8'h0c, d); check("R10 readback idle", d, 32'h0);
    endtask

    task automatic t_srst_cpu1();
        bus_write(8'h0c, 32'h0);
        check("R8 cpu1 forced", soft_rst, 32'd1 << 30);
        repeat (PULSE) @(negedge clk);
        check("R8 cpu1 cleared", soft_rst, 32'h0);
    endtask

    task automatic t_srst_extend();
        logic [31:0] exp = 32'h0000_0003 | 32'h0010_0000 | (32'd1 << 30);
        bus_write(8'h0c, 32'h0000_0003);
        repeat (3) @(negedge clk);
        bus_write(8'h0c, 32'h0010_0000);
        check("R9 merged", soft_rst, exp);
        repeat (PULSE - 1) @(negedge clk);
        check("R9 restarted count", soft_rst, exp);
        @(negedge clk);
        check("R9 cleared", soft_rst, 32'h0);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        bus_write(8'h34, 32'd7 << 24);
        bus_write(8'h30, 32'd1 << 18);
        bus_write(8'h20, 32'hFFFF_FFFF);
        bus_write(8'h38, 32'hFFFF_FFFF);
        bus_read(8'h20, d); check("R11 read zero", d, 32'h0);
        bus_read(8'h34, d); check("R11 clkctl kept", d, 32'h0700_0000);
        bus_read(8'h30, d); check("R11 misc kept", d, 32'h0004_0000);
        check("R11 no reset", soft_rst, 32'h0);
        check("R11 enables kept", 32'(clk_run_en), 32'h1FFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        repeat (2) @(negedge clk);
        t_status();
        t_gates();
        t_keep_all_ones();
        t_pci_sec();
        t_misc();
        t_srst_basic();
        t_srst_cpu1();
        t_srst_extend();
        t_unmapped();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        vectors++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule